// File: doc/BRIEF.md
# Crossbar DMA Device Interconnect

This block is a local interconnect reserved for DMA traffic. It links any of `NSRC` source-side device ports to any of `NDST` destination-side device ports. Because DMA beats travel through this fabric and not over the system bus, the processor keeps full use of the system bus while transfers run. Each DMA channel names one source port and one destination port. When it is started, the block decides in a single cycle whether the route can be granted. Channels that use disjoint ports then stream data at the same time. No arbiter sits between them, so no channel waits on another.

Every device port has a selector. While a live channel owns the port, the selector connects the device to the crossbar path. Otherwise it passes the system-bus signals through unchanged. A design-time mask lists which source/destination links physically exist, so links that are never used can be left out to build a partial crossbar. Data moves with a valid/ready handshake. Each destination has one output register, which adds exactly one cycle of latency and keeps full throughput.

Each channel runs a three-state machine: `CH_IDLE`, `CH_LIVE` and `CH_FAULT`. The transitions are:
- `CH_IDLE`→`CH_LIVE` (start, admitted)
- `CH_IDLE`→`CH_FAULT` (start, refused)
- `CH_FAULT`→`CH_LIVE` (retry admitted)
- `CH_FAULT`→`CH_FAULT` (retry refused)
- `CH_FAULT`→`CH_IDLE` (stop)
- `CH_LIVE`→`CH_IDLE` (stop)

Top module: `dma_xbar`

## Requirements
- R1: A channel whose start is admitted shows `ch_live` high from the cycle after the start pulse, for any source index below `NSRC` and any destination index below `NDST` whose mask bit is set.
- R2: Channels whose routes share no port are all admitted and carry data in the same cycles, with no delay caused by one another.
- R3: On a live route, a beat accepted at the source (`src_valid` and `src_ready` both high) appears on `dst_valid`/`dst_data` of the routed destination in the following cycle.
- R4: While a routed destination holds an undelivered beat and `dst_ready` is low, that beat stays on `dst_data` unchanged and the routed source sees `src_ready` low. Otherwise the routed source sees `src_ready` high.
- R5: A start whose source or destination port is owned by a live channel is refused, and `ch_err` of the requesting channel goes high from the next cycle. Among same-cycle starts, the channels are admitted in ascending index order, and a later channel is refused if an earlier admitted one took its port.
- R6: Link (s,d) exists only when bit `s*NDST+d` of `LINK_MASK` is 1. A start on a missing link, or with an index at or above the port count, is refused with `ch_err` set.
- R7: `src_dma_sel`/`dst_dma_sel` of a port are high exactly while a live channel owns it. A port not owned passes the system bus through: `dst_valid`/`dst_data` equal `sys_dst_valid`/`sys_dst_data`, and `src_ready` equals `sys_src_ready`.
- R8: A stop pulse clears `ch_live` in the next cycle. In that same cycle the channel's ports return to the system bus, and any undelivered beat in the destination register is discarded.
- R9: A start to a live channel is ignored and its route is kept. A stop wins over a simultaneous start. A start from the error state retries admission. A stop also clears `ch_err`.
- R10: During and right after reset, no channel is live or in error, and all selectors pick the system bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_start | input | NCH | Per-channel start pulse |
| ch_stop | input | NCH | Per-channel stop/complete pulse |
| ch_src_idx | input | NCH*SW | Requested source port per channel |
| ch_dst_idx | input | NCH*DIW | Requested destination port per channel |
| ch_live | output | NCH | Channel owns its route |
| ch_err | output | NCH | Channel's last request was refused |
| src_valid | input | NSRC | Source device has a DMA beat |
| src_data | input | NSRC*DW | Source device DMA data |
| src_ready | output | NSRC | Ready toward source device (muxed) |
| sys_src_ready | input | NSRC | System-bus ready toward source device |
| src_dma_sel | output | NSRC | Source device selector: 1 = crossbar |
| dst_valid | output | NDST | Valid toward destination device (muxed) |
| dst_data | output | NDST*DW | Data toward destination device (muxed) |
| dst_ready | input | NDST | Destination device ready |
| sys_dst_valid | input | NDST | System-bus valid toward destination device |
| sys_dst_data | input | NDST*DW | System-bus data toward destination device |
| dst_dma_sel | output | NDST | Destination device selector: 1 = crossbar |

## Verification
The hardest case to reach is a cycle where the admission chain matters. In that cycle, several channels start together while other channels hold ports and one channel is stopping. The ports of the stopping channel still count as busy, and a lower-numbered request may take a port that a higher one also wants. The stimulus first runs directed cycles that stack these conditions: same-cycle requests on one destination, a retry from the error state right after the owner stops, and a start together with a stop. After that comes a long phase of sparse random starts, stops and out-of-range indices. Random backpressure and system-bus traffic run throughout, so every ownership change also meets a held beat.

// File: rtl/dma_xbar_pkg.sv
package dma_xbar_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_LIVE  = 2'd1,
        CH_FAULT = 2'd2
    } ch_state_e;

endpackage

// File: rtl/dma_xbar_admit.sv
module dma_xbar_admit #(
    parameter int NSRC = 4,
    parameter int NDST = 4,
    parameter int NCH  = 4,
    parameter logic [NSRC*NDST-1:0] LINK_MASK = '1,
    parameter int SW   = $clog2(NSRC),
    parameter int DIW  = $clog2(NDST)
) (
    input  logic [NCH-1:0]     start,
    input  logic [NCH-1:0]     stop,
    input  logic [NCH-1:0]     live,
    input  logic [NCH*SW-1:0]  req_src,
    input  logic [NCH*DIW-1:0] req_dst,
    input  logic [NCH*SW-1:0]  cur_src,
    input  logic [NCH*DIW-1:0] cur_dst,
    output logic [NCH-1:0]     grant
);

    // Ports held by live channels are busy; requests then claim in index order.
    always_comb begin
        logic [NSRC-1:0] busy_s;
        logic [NDST-1:0] busy_d;
        logic [SW-1:0]   rs;
        logic [DIW-1:0]  rd;
        logic            ok;
        busy_s = '0;
        busy_d = '0;
        grant  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (live[c]) begin
                busy_s[cur_src[c*SW +: SW]]   = 1'b1;
                busy_d[cur_dst[c*DIW +: DIW]] = 1'b1;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            rs = req_src[c*SW +: SW];
            rd = req_dst[c*DIW +: DIW];
            ok = (int'(rs) < NSRC) && (int'(rd) < NDST);
            if (ok) begin
                ok = LINK_MASK[int'(rs)*NDST + int'(rd)] && !busy_s[rs] && !busy_d[rd];
            end
            if (start[c] && !stop[c] && !live[c] && ok) begin
                grant[c]   = 1'b1;
                busy_s[rs] = 1'b1;
                busy_d[rd] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_xbar_chan.sv
module dma_xbar_chan
    import dma_xbar_pkg::*;
#(
    parameter int SW  = 2,
    parameter int DIW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           stop,
    input  logic           grant,
    input  logic [SW-1:0]  req_src,
    input  logic [DIW-1:0] req_dst,
    output logic           live,
    output logic           err,
    output logic [SW-1:0]  route_src,
    output logic [DIW-1:0] route_dst
);

    ch_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_src <= '0;
            route_dst <= '0;
        end else if (state != CH_LIVE && start && !stop && grant) begin
            route_src <= req_src;
            route_dst <= req_dst;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            CH_IDLE, CH_FAULT: begin
                if (stop)       state_n = CH_IDLE;
                else if (start) state_n = grant ? CH_LIVE : CH_FAULT;
            end
            CH_LIVE: begin
                if (stop) state_n = CH_IDLE;
            end
            default: state_n = CH_IDLE;
        endcase
    end

    always_comb begin
        live = (state == CH_LIVE);
        err  = (state == CH_FAULT);
    end

    // R5
    refuse_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_LIVE && start && !stop && !grant) |=> err);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!live && !err));

    // R9
    live_route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !stop) |=> (live && $stable(route_src) && $stable(route_dst)));

endmodule

// File: rtl/dma_xbar_dport.sv
module dma_xbar_dport #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          owned,
    input  logic          x_valid,
    input  logic [DW-1:0] x_data,
    output logic          x_ready,
    input  logic          dst_ready,
    input  logic          sys_valid,
    input  logic [DW-1:0] sys_data,
    output logic          dst_valid,
    output logic [DW-1:0] dst_data,
    output logic          dma_sel
);

    logic          ov;
    logic [DW-1:0] od;

    assign x_ready = !ov || dst_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov <= 1'b0;
            od <= '0;
        end else if (!owned) begin
            ov <= 1'b0;
        end else if (x_ready) begin
            ov <= x_valid;
            od <= x_data;
        end
    end

    always_comb begin
        dma_sel   = owned;
        dst_valid = owned ? ov : sys_valid;
        dst_data  = owned ? od : sys_data;
    end

    // R4
    held_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && ov && !dst_ready) |=> (!owned || (ov && $stable(od))));

endmodule

// File: rtl/dma_xbar.sv
module dma_xbar #(
    parameter int NSRC = 4,
    parameter int NDST = 4,
    parameter int NCH  = 4,
    parameter int DW   = 32,
    parameter logic [NSRC*NDST-1:0] LINK_MASK = '1,
    localparam int SW  = $clog2(NSRC),
    localparam int DIW = $clog2(NDST)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_start,
    input  logic [NCH-1:0]       ch_stop,
    input  logic [NCH*SW-1:0]    ch_src_idx,
    input  logic [NCH*DIW-1:0]   ch_dst_idx,
    output logic [NCH-1:0]       ch_live,
    output logic [NCH-1:0]       ch_err,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*DW-1:0]   src_data,
    output logic [NSRC-1:0]      src_ready,
    input  logic [NSRC-1:0]      sys_src_ready,
    output logic [NSRC-1:0]      src_dma_sel,
    output logic [NDST-1:0]      dst_valid,
    output logic [NDST*DW-1:0]   dst_data,
    input  logic [NDST-1:0]      dst_ready,
    input  logic [NDST-1:0]      sys_dst_valid,
    input  logic [NDST*DW-1:0]   sys_dst_data,
    output logic [NDST-1:0]      dst_dma_sel
);

    logic [NCH-1:0]     grant;
    logic [NCH*SW-1:0]  rsrc_flat;
    logic [NCH*DIW-1:0] rdst_flat;
    logic [SW-1:0]      rsrc [NCH];
    logic [DIW-1:0]     rdst [NCH];

    logic [NSRC-1:0]    src_own;
    logic [DIW-1:0]     src_to   [NSRC];
    logic [NDST-1:0]    dst_own;
    logic [SW-1:0]      dst_from [NDST];
    logic [NCH-1:0]     shit     [NSRC];
    logic [NCH-1:0]     dhit     [NDST];
    logic [NDST-1:0]    xrdy;

    dma_xbar_admit #(
        .NSRC(NSRC), .NDST(NDST), .NCH(NCH), .LINK_MASK(LINK_MASK), .SW(SW), .DIW(DIW)
    ) u_admit (
        .start  (ch_start),
        .stop   (ch_stop),
        .live   (ch_live),
        .req_src(ch_src_idx),
        .req_dst(ch_dst_idx),
        .cur_src(rsrc_flat),
        .cur_dst(rdst_flat),
        .grant  (grant)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_xbar_chan #(.SW(SW), .DIW(DIW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (ch_start[c]),
            .stop     (ch_stop[c]),
            .grant    (grant[c]),
            .req_src  (ch_src_idx[c*SW +: SW]),
            .req_dst  (ch_dst_idx[c*DIW +: DIW]),
            .live     (ch_live[c]),
            .err      (ch_err[c]),
            .route_src(rsrc[c]),
            .route_dst(rdst[c])
        );
        assign rsrc_flat[c*SW +: SW]   = rsrc[c];
        assign rdst_flat[c*DIW +: DIW] = rdst[c];
    end

    // Ownership decode from the live routes.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            shit[s]   = '0;
            src_own[s] = 1'b0;
            src_to[s]  = '0;
        end
        for (int d = 0; d < NDST; d++) begin
            dhit[d]     = '0;
            dst_own[d]  = 1'b0;
            dst_from[d] = '0;
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_live[c]) begin
                shit[rsrc[c]][c]  = 1'b1;
                src_own[rsrc[c]]  = 1'b1;
                src_to[rsrc[c]]   = rdst[c];
                dhit[rdst[c]][c]  = 1'b1;
                dst_own[rdst[c]]  = 1'b1;
                dst_from[rdst[c]] = rsrc[c];
            end
        end
    end

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        logic          xv;
        logic [DW-1:0] xd;
        assign xv = src_valid[dst_from[d]];
        assign xd = src_data[dst_from[d]*DW +: DW];

        dma_xbar_dport #(.DW(DW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .owned    (dst_own[d]),
            .x_valid  (xv),
            .x_data   (xd),
            .x_ready  (xrdy[d]),
            .dst_ready(dst_ready[d]),
            .sys_valid(sys_dst_valid[d]),
            .sys_data (sys_dst_data[d*DW +: DW]),
            .dst_valid(dst_valid[d]),
            .dst_data (dst_data[d*DW +: DW]),
            .dma_sel  (dst_dma_sel[d])
        );

        // R5
        dst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(dhit[d]));

        // R6
        link_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dst_dma_sel[d] |-> LINK_MASK[int'(dst_from[d])*NDST + d]);
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_dma_sel[s] = src_own[s];
        assign src_ready[s]   = src_own[s] ? xrdy[src_to[s]] : sys_src_ready[s];

        // R5
        src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(shit[s]));
    end

endmodule

// File: tb/dma_xbar_test.sv
module dma_xbar_test;

    localparam int NS = 3, ND = 3, NC = 3, W = 8;
    localparam logic [8:0] MASK = 9'b110111111; // link src2->dst0 (bit 6) absent

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NC-1:0]   ch_start = '0, ch_stop = '0;
    logic [NC*2-1:0] ch_src_idx = '0, ch_dst_idx = '0;
    logic [NC-1:0]   ch_live, ch_err;
    logic [NS-1:0]   src_valid = '0, sys_src_ready = '0;
    logic [NS*W-1:0] src_data = '0;
    logic [NS-1:0]   src_ready, src_dma_sel;
    logic [ND-1:0]   dst_valid, dst_dma_sel;
    logic [ND*W-1:0] dst_data;
    logic [ND-1:0]   dst_ready = '1, sys_dst_valid = '0;
    logic [ND*W-1:0] sys_dst_data = '0;

    dma_xbar #(.NSRC(NS), .NDST(ND), .NCH(NC), .DW(W), .LINK_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n),
        .ch_start(ch_start), .ch_stop(ch_stop),
        .ch_src_idx(ch_src_idx), .ch_dst_idx(ch_dst_idx),
        .ch_live(ch_live), .ch_err(ch_err),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .sys_src_ready(sys_src_ready), .src_dma_sel(src_dma_sel),
        .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready),
        .sys_dst_valid(sys_dst_valid), .sys_dst_data(sys_dst_data),
        .dst_dma_sel(dst_dma_sel)
    );

    int checks = 0, errors = 0;
    string phase = "R10";
    bit bp_mode = 0;

    // reference model state
    bit m_live[NC], m_err[NC];
    int m_s[NC], m_d[NC];
    bit m_ov[ND];
    int m_od[ND];

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) %s: actual %h expected %h", tag, phase, what, act, exp);
        end
    endtask

    task automatic scramble();
        src_data      = W*NS'($urandom);
        sys_dst_data  = W*ND'($urandom);
        src_valid     = NS'($urandom);
        sys_src_ready = NS'($urandom);
        sys_dst_valid = ND'($urandom);
        dst_ready     = bp_mode ? ND'($urandom | $urandom) : '1;
    endtask

    task automatic cyc();
        logic [NC-1:0] el, ee;
        logic [NS-1:0] essel, esrdy;
        logic [ND-1:0] edsel, edv, dmask;
        logic [ND*W-1:0] edd, ad;
        bit nl[NC], ne[NC], bs[NS], bd[ND], nov[ND];
        int ns_[NC], nd_[NC], nod[ND], owner_d[ND], owner_s[NS];
        #1;
        for (int d = 0; d < ND; d++) owner_d[d] = -1;
        for (int s = 0; s < NS; s++) owner_s[s] = -1;
        for (int c = 0; c < NC; c++) if (m_live[c]) begin
            owner_d[m_d[c]] = m_s[c];
            owner_s[m_s[c]] = m_d[c];
        end
        for (int c = 0; c < NC; c++) begin el[c] = m_live[c]; ee[c] = m_err[c]; end
        edd = '0; ad = '0;
        for (int d = 0; d < ND; d++) begin
            edsel[d] = owner_d[d] >= 0;
            edv[d]   = edsel[d] ? m_ov[d] : sys_dst_valid[d];
            dmask[d] = edv[d];
            if (edv[d]) begin
                edd[d*W +: W] = edsel[d] ? W'(m_od[d]) : sys_dst_data[d*W +: W];
                ad[d*W +: W]  = dst_data[d*W +: W];
            end
        end
        for (int s = 0; s < NS; s++) begin
            essel[s] = owner_s[s] >= 0;
            esrdy[s] = essel[s] ? (!m_ov[owner_s[s]] || dst_ready[owner_s[s]]) : sys_src_ready[s];
        end
        chk(ch_live === el, "R2", "ch_live", 32'(ch_live), 32'(el));
        chk(ch_err === ee, "R5", "ch_err", 32'(ch_err), 32'(ee));
        chk({src_dma_sel, dst_dma_sel} === {essel, edsel}, "R7", "selectors",
            32'({src_dma_sel, dst_dma_sel}), 32'({essel, edsel}));
        chk(src_ready === esrdy, "R4", "src_ready", 32'(src_ready), 32'(esrdy));
        chk(dst_valid === edv, "R3", "dst_valid", 32'(dst_valid), 32'(edv));
        chk(ad === edd, "R3", "dst_data", 32'(ad), 32'(edd));
        // next state
        for (int s = 0; s < NS; s++) bs[s] = 0;
        for (int d = 0; d < ND; d++) bd[d] = 0;
        for (int c = 0; c < NC; c++) if (m_live[c]) begin bs[m_s[c]] = 1; bd[m_d[c]] = 1; end
        for (int c = 0; c < NC; c++) begin
            int rs, rd;
            nl[c] = m_live[c]; ne[c] = m_err[c]; ns_[c] = m_s[c]; nd_[c] = m_d[c];
            rs = int'(ch_src_idx[c*2 +: 2]);
            rd = int'(ch_dst_idx[c*2 +: 2]);
            if (ch_stop[c]) begin
                nl[c] = 0; ne[c] = 0;
            end else if (ch_start[c] && !m_live[c]) begin
                if (rs < NS && rd < ND && MASK[rs*ND + rd] && !bs[rs] && !bd[rd]) begin
                    nl[c] = 1; ne[c] = 0; ns_[c] = rs; nd_[c] = rd;
                    bs[rs] = 1; bd[rd] = 1;
                end else ne[c] = 1;
            end
        end
        for (int d = 0; d < ND; d++) begin
            nov[d] = m_ov[d]; nod[d] = m_od[d];
            if (owner_d[d] < 0) nov[d] = 0;
            else if (!m_ov[d] || dst_ready[d]) begin
                nov[d] = src_valid[owner_d[d]];
                nod[d] = int'(src_data[owner_d[d]*W +: W]);
            end
        end
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            m_live[c] = nl[c]; m_err[c] = ne[c]; m_s[c] = ns_[c]; m_d[c] = nd_[c];
        end
        for (int d = 0; d < ND; d++) begin m_ov[d] = nov[d]; m_od[d] = nod[d]; end
        @(negedge clk);
        ch_start = '0;
        ch_stop  = '0;
        scramble();
    endtask

    task automatic req(int c, int s, int d);
        ch_src_idx[c*2 +: 2] = 2'(s);
        ch_dst_idx[c*2 +: 2] = 2'(d);
        ch_start[c] = 1'b1;
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin m_live[c] = 0; m_err[c] = 0; m_s[c] = 0; m_d[c] = 0; end
        for (int d = 0; d < ND; d++) begin m_ov[d] = 0; m_od[d] = 0; end
        repeat (2) @(negedge clk);
        // R10: reset state
        chk(ch_live === '0 && ch_err === '0, "R10", "chan flags in reset", 32'({ch_live, ch_err}), 0);
        chk(src_dma_sel === '0 && dst_dma_sel === '0, "R10", "selectors in reset",
            32'({src_dma_sel, dst_dma_sel}), 0);
        rst_n = 1'b1;
        scramble();
        cyc();
        phase = "R1";
        req(0, 0, 1); cyc();
        repeat (6) cyc();
        phase = "R2";
        req(1, 1, 2); cyc();
        repeat (6) cyc();
        phase = "R5";
        req(2, 0, 0); cyc();    // source 0 owned by channel 0
        cyc();
        req(2, 2, 1); cyc();    // destination 1 owned by channel 0
        cyc();
        phase = "R4";
        bp_mode = 1; scramble();
        repeat (12) cyc();
        phase = "R9";
        req(1, 2, 0); cyc();    // start to live channel ignored
        cyc();
        phase = "R8";
        ch_stop[0] = 1'b1; cyc();
        repeat (3) cyc();
        phase = "R9";
        req(2, 0, 0); cyc();    // retry from error state now admitted
        repeat (3) cyc();
        ch_stop = '1; cyc();
        req(0, 0, 0); ch_stop[0] = 1'b1; cyc(); // stop beats start
        phase = "R6";
        req(0, 2, 0); cyc();    // missing link
        req(1, 3, 1); cyc();    // out-of-range source
        req(2, 1, 3); cyc();    // out-of-range destination
        cyc();
        ch_stop = '1; cyc();
        phase = "R5";
        req(0, 2, 1); req(1, 0, 1); req(2, 1, 2); cyc(); // 0 and 2 win, 1 refused
        repeat (4) cyc();
        ch_stop = '1; cyc();
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(7) == 0) req(c, $urandom_range(3), $urandom_range(3));
                if ($urandom_range(15) == 0) ch_stop[c] = 1'b1;
            end
            cyc();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule